// File: doc/BRIEF.md
# Agree-Style Conditional Branch Direction Predictor

This block predicts whether a conditional branch will be taken. Each branch owns a small saturating bias state in a local table, selected by low branch-address bits. A second table of two-bit counters, selected by mixing a folded global outcome history with branch-address bits, decides whether the final prediction keeps that bias or flips it. The counters learn whether branches tend to agree with their own bias in a given history context. Because they record agreement rather than direction, two branches that share an entry do less harm to each other.

The front end presents a branch address, the branch's static direction and two hint flags on the predict port, and reads a taken/not-taken answer back in the same cycle. When a branch resolves, the back end reports its address, its kind, its static direction, whether it carried the alternating hint, and its actual outcome. Only conditional resolves train the tables and advance the history. A branch that carries the alternating hint has its bias forced to swap between the two weak states on every event, so a strict taken/not-taken alternation can be learned.

Top module: `agree_predictor`

## Requirements
- R1: During and after a synchronous active-low reset, the global history is all zeros, every agree counter is weakly agree (code 1), and every local entry is unseen.
- R2: The prediction is the local bias (bit 1 of the local state) when bit 1 of the selected agree counter is 0, and the inverse of the bias when that bit is 1. The output is 0 when `pred_valid` is low.
- R3: The local state uses the codes 0 = strongly not taken, 1 = weakly not taken, 2 = weakly taken and 3 = strongly taken. Without the alternating hint, a conditional resolve moves it one step up when the outcome is taken and one step down when it is not taken, saturating at 0 and at 3.
- R4: The state of an unseen local entry is 2 when the branch's static direction is taken and 1 when it is not taken. This applies both to predictions and to the first update of the entry.
- R5: The agree counter uses the codes 0 = strongly agree, 1 = weakly agree, 2 = weakly disagree and 3 = strongly disagree. On a conditional resolve it steps toward 0 when the outcome equals the local bias held before the update, and toward 3 otherwise, saturating at both ends.
- R6: The history register is `HIST_W` bits wide. Each conditional resolve shifts the actual outcome into bit 0.
- R7: Resolves of kind 1 (unconditional jump), 2 (indirect) or 3 (call/return) change neither the history nor either table. Kind 0 means conditional.
- R8: A conditional resolve with `res_alt` set writes state 2 if the bias before the update was not taken, and state 1 otherwise, whatever the outcome.
- R9: `pred_invalid` is 1 exactly when `pred_valid`, `pred_hint_dir` and `pred_hint_alt` are all set.
- R10: The local index is address bits [LIDX_W+1:2]. The global index is address bits [GIDX_W+1:2] XOR the history folded to `GIDX_W` bits, where history bit i is XORed into folded bit i mod `GIDX_W`. The predict port uses the history as it stands at the time of the request. A resolve uses the history as it stood before its own shift.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pred_valid | input | 1 | Predict request present |
| pred_addr | input | ADDR_W | Address of the branch to predict |
| pred_static_taken | input | 1 | Static direction of the branch (1 = taken) |
| pred_hint_dir | input | 1 | Static direction hint present on the branch |
| pred_hint_alt | input | 1 | Alternating hint present on the branch |
| pred_taken | output | 1 | Predicted direction (1 = taken) |
| pred_invalid | output | 1 | Request carries both hints at once |
| res_valid | input | 1 | Resolve event present |
| res_addr | input | ADDR_W | Address of the resolved branch |
| res_kind | input | 2 | 0 conditional, 1 jump, 2 indirect, 3 call/return |
| res_taken | input | 1 | Actual outcome |
| res_static_taken | input | 1 | Static direction of the resolved branch |
| res_alt | input | 1 | Resolved branch carried the alternating hint |

## Verification
On every cycle, the embedded properties check four things. A non-conditional cycle leaves the history untouched, and a conditional one shifts in the actual outcome. A taken outcome never leaves a local entry strongly not taken, and an agreeing outcome never leaves a counter strongly disagree. Every alternating-hint update lands on a weak state. Whether predictions are right over long mixed sequences can only be shown by the bench's scenarios. These cover reset defaults, aliasing between addresses, saturation, history-dependent indexing, the three ignored branch kinds, alternation from both static directions and the hint-conflict flag. In each scenario the bench compares every predict answer against an arithmetic model of the tables.

// File: rtl/agree_bp_pkg.sv
// Package: shared encodings and state-step helpers for the agree predictor.
// Assumes two-bit states everywhere; codes are fixed by the requirements.
package agree_bp_pkg;

    typedef enum logic [1:0] {
        BR_COND     = 2'd0,
        BR_JUMP     = 2'd1,
        BR_INDIRECT = 2'd2,
        BR_CALLRET  = 2'd3
    } br_kind_e;

    // Local bias state codes
    localparam logic [1:0] LS_SNT = 2'd0;
    localparam logic [1:0] LS_WNT = 2'd1;
    localparam logic [1:0] LS_WT  = 2'd2;
    localparam logic [1:0] LS_ST  = 2'd3;

    // Agree counter codes
    localparam logic [1:0] GC_SA = 2'd0;
    localparam logic [1:0] GC_WA = 2'd1;
    localparam logic [1:0] GC_WD = 2'd2;
    localparam logic [1:0] GC_SD = 2'd3;

    // One saturating step of a two-bit state, up or down.
    function automatic logic [1:0] sat_step(input logic [1:0] s, input logic up);
        logic [1:0] r;
        if (up) r = (s == 2'd3) ? s : s + 2'd1;
        else    r = (s == 2'd0) ? s : s - 2'd1;
        return r;
    endfunction

    // Initial local state of a never-seen branch from its static direction.
    function automatic logic [1:0] init_state(input logic static_taken);
        return static_taken ? LS_WT : LS_WNT;
    endfunction

endpackage

// File: rtl/agree_hist_reg.sv
// Global outcome history: shifts one outcome in per enabled cycle and
// presents the history folded down to the index width of the agree table.
// Assumes IDX_W <= HIST_W.
module agree_hist_reg #(
    parameter int HIST_W = 16,
    parameter int IDX_W  = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_en,
    input  logic              shift_bit,
    output logic [HIST_W-1:0] hist_o,
    output logic [IDX_W-1:0]  folded_o
);

    logic [HIST_W-1:0] hist_q;

    // Shift register update; reset clears the history.
    always_ff @(posedge clk) begin
        if (!rst_n)        hist_q <= '0;
        else if (shift_en) hist_q <= {hist_q[HIST_W-2:0], shift_bit};
    end

    // Fold: history bit i lands on folded bit i mod IDX_W.
    always_comb begin
        folded_o = '0;
        for (int i = 0; i < HIST_W; i++) begin
            folded_o[i % IDX_W] = folded_o[i % IDX_W] ^ hist_q[i];
        end
    end

    assign hist_o = hist_q;

    // R7
    hist_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_en |=> $stable(hist_q));

    // R6
    hist_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en |=> hist_q[0] == $past(shift_bit));

endmodule

// File: rtl/agree_local_table.sv
// Per-branch local bias table: a two-bit state and a seen flag per entry.
// Unseen entries read as the weak state matching the static direction.
// One combinational predict read port, one read-modify-write update port.
module agree_local_table #(
    parameter int LIDX_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LIDX_W-1:0] rd_idx,
    input  logic              rd_static,
    output logic [1:0]        rd_state,
    input  logic              up_en,
    input  logic [LIDX_W-1:0] up_idx,
    input  logic              up_static,
    input  logic              up_taken,
    input  logic              up_alt,
    output logic [1:0]        up_state
);
    import agree_bp_pkg::*;

    localparam int DEPTH = 1 << LIDX_W;

    logic [1:0]       st_q [DEPTH];
    logic [DEPTH-1:0] seen_q;
    logic [1:0]       nxt_state;

    // Predict read, substituting the static initial state for unseen entries.
    always_comb begin
        rd_state = seen_q[rd_idx] ? st_q[rd_idx] : init_state(rd_static);
    end

    // Current state at the update index, same substitution.
    always_comb begin
        up_state = seen_q[up_idx] ? st_q[up_idx] : init_state(up_static);
    end

    // Next state: alternating hint swaps weak states, else saturating step.
    always_comb begin
        if (up_alt) nxt_state = up_state[1] ? LS_WNT : LS_WT;
        else        nxt_state = sat_step(up_state, up_taken);
    end

    // Seen flags: cleared at reset, set on first update.
    always_ff @(posedge clk) begin
        if (!rst_n)     seen_q <= '0;
        else if (up_en) seen_q[up_idx] <= 1'b1;
    end

    // State storage write; contents are only meaningful once seen.
    always_ff @(posedge clk) begin
        if (rst_n && up_en) st_q[up_idx] <= nxt_state;
    end

    // R3
    local_taken_leaves_snt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        up_en && !up_alt && up_taken |=> st_q[$past(up_idx)] != LS_SNT);

    // R8
    local_alt_weak_chk: assert property (@(posedge clk) disable iff (!rst_n)
        up_en && up_alt |=> (st_q[$past(up_idx)] == LS_WNT) || (st_q[$past(up_idx)] == LS_WT));

endmodule

// File: rtl/agree_global_table.sv
// Agree/disagree counter table: two-bit saturating counters, reset to
// weakly agree. Combinational read for prediction, read-modify-write update.
module agree_global_table #(
    parameter int GIDX_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [GIDX_W-1:0] rd_idx,
    output logic [1:0]        rd_ctr,
    input  logic              up_en,
    input  logic [GIDX_W-1:0] up_idx,
    input  logic              up_agree
);
    import agree_bp_pkg::*;

    localparam int DEPTH = 1 << GIDX_W;

    logic [1:0] ctr_q [DEPTH];
    logic [1:0] up_ctr;

    // Predict read and update read.
    always_comb begin
        rd_ctr = ctr_q[rd_idx];
        up_ctr = ctr_q[up_idx];
    end

    // Counter array: reset to weakly agree, agree steps toward code 0.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) ctr_q[i] <= GC_WA;
        end else if (up_en) begin
            ctr_q[up_idx] <= sat_step(up_ctr, !up_agree);
        end
    end

    // R5
    global_agree_leaves_sd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        up_en && up_agree |=> ctr_q[$past(up_idx)] != GC_SD);

    // R5
    global_disagree_leaves_sa_chk: assert property (@(posedge clk) disable iff (!rst_n)
        up_en && !up_agree |=> ctr_q[$past(up_idx)] != GC_SA);

endmodule

// File: rtl/agree_predictor.sv
// Top: agree-style conditional direction predictor. Combines the local bias
// with an agree counter chosen by folded history XOR address. Only
// conditional resolves train the tables and advance the history.
// Assumes GIDX_W <= HIST_W and word-aligned branch addresses (bits [1:0] unused).
module agree_predictor #(
    parameter int ADDR_W = 32,
    parameter int HIST_W = 16,
    parameter int GIDX_W = 10,
    parameter int LIDX_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pred_valid,
    input  logic [ADDR_W-1:0] pred_addr,
    input  logic              pred_static_taken,
    input  logic              pred_hint_dir,
    input  logic              pred_hint_alt,
    output logic              pred_taken,
    output logic              pred_invalid,
    input  logic              res_valid,
    input  logic [ADDR_W-1:0] res_addr,
    input  logic [1:0]        res_kind,
    input  logic              res_taken,
    input  logic              res_static_taken,
    input  logic              res_alt
);
    import agree_bp_pkg::*;

    logic [HIST_W-1:0] hist;
    logic [GIDX_W-1:0] hist_fold;
    logic              cond_upd;
    logic [1:0]        p_local, p_ctr, r_local;
    logic [GIDX_W-1:0] p_gidx, r_gidx;
    logic [LIDX_W-1:0] p_lidx, r_lidx;
    logic              unused_bits;

    // Only conditional resolves train anything.
    always_comb begin
        cond_upd = res_valid && (br_kind_e'(res_kind) == BR_COND);
    end

    // Index formation for both ports.
    always_comb begin
        p_lidx = pred_addr[LIDX_W+1:2];
        r_lidx = res_addr[LIDX_W+1:2];
        p_gidx = pred_addr[GIDX_W+1:2] ^ hist_fold;
        r_gidx = res_addr[GIDX_W+1:2] ^ hist_fold;
    end

    assign unused_bits = ^{pred_addr, res_addr, hist};

    agree_hist_reg #(.HIST_W(HIST_W), .IDX_W(GIDX_W)) i_hist (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (cond_upd),
        .shift_bit(res_taken),
        .hist_o   (hist),
        .folded_o (hist_fold)
    );

    agree_local_table #(.LIDX_W(LIDX_W)) i_local (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_idx   (p_lidx),
        .rd_static(pred_static_taken),
        .rd_state (p_local),
        .up_en    (cond_upd),
        .up_idx   (r_lidx),
        .up_static(res_static_taken),
        .up_taken (res_taken),
        .up_alt   (res_alt),
        .up_state (r_local)
    );

    agree_global_table #(.GIDX_W(GIDX_W)) i_global (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_idx  (p_gidx),
        .rd_ctr  (p_ctr),
        .up_en   (cond_upd),
        .up_idx  (r_gidx),
        .up_agree(res_taken == r_local[1])
    );

    // Final direction: bias kept on agree, inverted on disagree.
    always_comb begin
        pred_taken   = pred_valid && (p_local[1] ^ p_ctr[1]);
        pred_invalid = pred_valid && pred_hint_dir && pred_hint_alt;
    end

endmodule

// File: tb/test_agree_predictor.sv
`timescale 1ns/1ps
module test_agree_predictor;
    localparam int AW = 32;
    localparam int HW = 16;
    localparam int GW = 4;
    localparam int LW = 3;

    logic clk = 0;
    logic rst_n = 0;
    logic pred_valid = 0, pred_static_taken = 0, pred_hint_dir = 0, pred_hint_alt = 0;
    logic [AW-1:0] pred_addr = '0;
    logic pred_taken, pred_invalid;
    logic res_valid = 0, res_taken = 0, res_static_taken = 0, res_alt = 0;
    logic [AW-1:0] res_addr = '0;
    logic [1:0] res_kind = 0;

    int n_chk = 0, n_fail = 0;

    // Arithmetic model of the tables
    bit [1:0] m_ls [1<<LW];
    bit       m_seen [1<<LW];
    bit [1:0] m_gc [1<<GW];
    bit [HW-1:0] m_h;
    bit [15:0] lfsr = 16'hACE1;

    always #4 clk = ~clk;

    agree_predictor #(.ADDR_W(AW), .HIST_W(HW), .GIDX_W(GW), .LIDX_W(LW)) i_agree_predictor (
        .clk(clk), .rst_n(rst_n), .pred_valid(pred_valid), .pred_addr(pred_addr),
        .pred_static_taken(pred_static_taken), .pred_hint_dir(pred_hint_dir),
        .pred_hint_alt(pred_hint_alt), .pred_taken(pred_taken), .pred_invalid(pred_invalid),
        .res_valid(res_valid), .res_addr(res_addr), .res_kind(res_kind), .res_taken(res_taken),
        .res_static_taken(res_static_taken), .res_alt(res_alt));

    function automatic bit [GW-1:0] m_fold();
        bit [GW-1:0] f = '0;
        for (int i = 0; i < HW; i++) f[i % GW] ^= m_h[i];
        return f;
    endfunction

    function automatic bit [1:0] m_local(bit [AW-1:0] a, bit st);
        int li = int'(a[LW+1:2]);
        return m_seen[li] ? m_ls[li] : (st ? 2'd2 : 2'd1);
    endfunction

    function automatic bit m_pred(bit [AW-1:0] a, bit st);
        int gi = int'(a[GW+1:2] ^ m_fold());
        return m_local(a, st)[1] ^ m_gc[gi][1];
    endfunction

    task automatic m_reset();
        for (int i = 0; i < (1<<LW); i++) m_seen[i] = 0;
        for (int i = 0; i < (1<<GW); i++) m_gc[i] = 2'd1;
        m_h = '0;
    endtask

    task automatic print_summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    task automatic check(string tag, bit act, bit exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0b expected %0b", tag, act, exp);
        end
    endtask

    task automatic check_pred(string tag, bit [AW-1:0] a, bit st);
        pred_valid = 1; pred_addr = a; pred_static_taken = st;
        #1;
        check(tag, pred_taken, m_pred(a, st));
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        m_reset();
    endtask

    // Drive one resolve, let one edge pass, update the model.
    task automatic resolve(bit [AW-1:0] a, bit [1:0] kind, bit t, bit st, bit alt);
        @(negedge clk);
        res_valid = 1; res_addr = a; res_kind = kind; res_taken = t;
        res_static_taken = st; res_alt = alt;
        @(negedge clk);
        res_valid = 0;
        if (kind == 2'd0) begin
            int li = int'(a[LW+1:2]);
            int gi = int'(a[GW+1:2] ^ m_fold());
            bit [1:0] cur = m_local(a, st);
            if (t == cur[1]) m_gc[gi] = (m_gc[gi] == 0) ? 2'd0 : m_gc[gi] - 2'd1;
            else             m_gc[gi] = (m_gc[gi] == 3) ? 2'd3 : m_gc[gi] + 2'd1;
            if (alt) m_ls[li] = cur[1] ? 2'd1 : 2'd2;
            else if (t) m_ls[li] = (cur == 3) ? 2'd3 : cur + 2'd1;
            else        m_ls[li] = (cur == 0) ? 2'd0 : cur - 2'd1;
            m_seen[li] = 1;
            m_h = {m_h[HW-2:0], t};
        end
    endtask

    function automatic bit [15:0] step_lfsr(bit [15:0] x);
        return {x[14:0], x[15] ^ x[13] ^ x[12] ^ x[10]};
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        print_summary();
        $finish;
    end

    initial begin
        do_reset();
        // R1 R4: all addresses, both static directions, right after reset
        for (int a = 0; a < 32; a++)
            for (int s = 0; s < 2; s++) begin
                pred_valid = 1; pred_addr = AW'(a * 4); pred_static_taken = s[0];
                #1;
                check("R1 R4 reset default", pred_taken, s[0]);
            end
        pred_valid = 0; #1;
        check("R2 valid low", pred_taken, 1'b0);

        // R3: saturate one branch upward, then downward
        for (int k = 0; k < 5; k++) begin
            resolve(32'h8, 2'd0, 1'b1, 1'b0, 1'b0);
            check_pred("R3 up", 32'h8, 1'b0);
        end
        for (int k = 0; k < 5; k++) begin
            resolve(32'h8, 2'd0, 1'b0, 1'b0, 1'b0);
            check_pred("R3 down", 32'h8, 1'b0);
        end

        // R2 R5 R6 R10: pseudo-random mixed conditional traffic with aliasing
        for (int n = 0; n < 400; n++) begin
            bit [AW-1:0] a;
            lfsr = step_lfsr(lfsr);
            a = AW'({lfsr[4:0], 2'b00});
            resolve(a, 2'd0, lfsr[7] | lfsr[9], lfsr[5], 1'b0);
            check_pred("R5 R10 resolved", a, lfsr[5]);
            check_pred("R2 R6 neighbour", a ^ 32'h14, lfsr[6]);
            check_pred("R10 alias", a ^ 32'h40, lfsr[5]);
        end

        // R7: non-conditional kinds must not disturb anything
        for (int k = 1; k < 4; k++)
            for (int n = 0; n < 8; n++)
                resolve(AW'(n * 4), k[1:0], n[0], n[1], n[2]);
        for (int a = 0; a < 32; a++)
            for (int s = 0; s < 2; s++)
                check_pred("R7 ignored kinds", AW'(a * 4), s[0]);

        // R8: alternating hint from both static directions, constant outcome
        do_reset();
        for (int k = 0; k < 6; k++) begin
            resolve(32'h4, 2'd0, 1'b1, 1'b0, 1'b1);
            check_pred("R8 alt from NT", 32'h4, 1'b0);
        end
        for (int k = 0; k < 6; k++) begin
            resolve(32'h18, 2'd0, 1'b0, 1'b1, 1'b1);
            check_pred("R8 alt from T", 32'h18, 1'b1);
        end

        // R9: every hint combination, with and without a request
        for (int c = 0; c < 8; c++) begin
            pred_valid = c[2]; pred_hint_dir = c[1]; pred_hint_alt = c[0];
            #1;
            check("R9 hint conflict", pred_invalid, c[2] & c[1] & c[0]);
        end

        print_summary();
        $finish;
    end
endmodule